// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block carries out one PHY management transaction for each 32-bit command word that software writes into its command register. When the management port is enabled and no frame is in flight, the write is accepted. The engine then produces the management clock by dividing the system clock, sends 32 preamble ones, and shifts the command word out MSB first on the data line.

For a read, the engine releases the data line for the turnaround and data bit times. It samples the sixteen bits that the PHY returns on rising clock edges and places them in the low half of the command register. An idle flag is low for the whole frame, so software polls it and then reads the result.

The data line is presented as three separate signals: a driven value, an output enable, and an input. The pad and the pull-up sit outside the block.

Top module: `mdio_mgmt`

## Requirements
- R1: The command word is laid out as follows: start code in bits 31:30, operation in 29:28, PHY address in 27:23, register address in 22:18, turnaround in 17:16 and data in 15:0. For any operation other than read, the frame is 32 ones followed by command bits 31 down to 0. Each bit is held for one full management clock period and is stable at the rising edge.
- R2: Operation code 10 selects a read. During a read, the output enable is high for the first 46 bit times (the preamble plus bits 31:18) and low for the last 18 bit times (turnaround and data).
- R3: After a read, bits 15:0 of the command register hold the 16 values sampled on the last 16 rising management clock edges. The first sample goes to bit 15. Bits 31:16 keep the value that was written.
- R4: The management clock period is 8 << clk_sel system clock cycles, with a 50% duty cycle, so clk_sel = 3 gives divide by 64. clk_sel is captured when a command is accepted, and later changes to it have no effect on the frame in flight. The clock is low whenever the block is idle.
- R5: The data output and the output enable change only while the management clock is low, which means they change after a falling edge.
- R6: After reset the idle flag is high. It goes low in the cycle after an accepted write and returns high 64 × (8 << clk_sel) + 1 cycles after that write's clock edge, once the 64th falling edge has occurred.
- R7: A command write while idle is low is ignored. The frame in flight and the final register contents are those of the original command.
- R8: While mgmt_en is low, command writes are ignored: idle stays high and the register is unchanged. Dropping mgmt_en during a frame ends the frame, so idle is high and the clock is low in the next cycle.
- R9: In reset, idle is 1, mdc is 0, mdio_oe is 0 and cmd_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mgmt_en | input | 1 | Management port enable |
| clk_sel | input | 2 | Clock divide select, period 8 << clk_sel |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Command register contents, read data in the low half |
| idle | output | 1 | High when no frame is in flight |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line value seen at the pad |

## Verification
Two events can collide in the same cycle.

The first is a new command write landing while a frame is shifting. The bench strobes a write with an inverted word midway through a frame. It then requires that the captured frame bits and the final register value still match the first command.

The second is a loss of the port enable while the clock divider is mid-period. The bench drops the enable in the middle of a frame and requires idle high and the clock low one cycle later. It then requires that a following read runs to completion as normal.

// File: rtl/mdio_pkg.sv
// Shared constants for the management frame engine: frame geometry,
// command field positions and the read operation code.
package mdio_pkg;
    localparam int PRE_BITS   = 32;
    localparam int CMD_BITS   = 32;
    localparam int FRAME_BITS = PRE_BITS + CMD_BITS;
    localparam int DATA_W     = 16;
    localparam int OP_HI      = 29;
    localparam int OP_LO      = 28;
    localparam logic [1:0] OP_READ = 2'b10;
    // Bit 17 of the command is the first turnaround bit.
    localparam int TA_FIRST   = PRE_BITS + (CMD_BITS - 1 - 17);
    localparam int DATA_FIRST = FRAME_BITS - DATA_W;
endpackage

// File: rtl/mdio_clkgen.sv
// Management clock generator.
// Divides clk by (BASE_DIV << sel_q). sel_q is captured on launch.
// Emits one-cycle strobes in the cycle after each rising or falling edge.
// Assumes BASE_DIV is even and at least 4. Clock held low when run is low.
module mdio_clkgen #(
    parameter int BASE_DIV = 8,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             launch,
    input  logic [SEL_W-1:0] sel,
    output logic             mdc,
    output logic             rise_p,
    output logic             fall_p
);
    localparam int HALF_BASE = BASE_DIV / 2;
    localparam int MAX_HALF  = HALF_BASE << ((1 << SEL_W) - 1);
    localparam int CNT_W     = $clog2(MAX_HALF + 1);

    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half;

    assign half = CNT_W'(HALF_BASE) << sel_q;

    // Capture the divide select when a frame is launched.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (launch) sel_q <= sel;
    end

    // Half-period counter, clock toggle and edge strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt    <= '0;
            mdc    <= 1'b0;
            rise_p <= 1'b0;
            fall_p <= 1'b0;
        end else begin
            rise_p <= 1'b0;
            fall_p <= 1'b0;
            if (cnt == half - 1'b1) begin
                cnt    <= '0;
                mdc    <= ~mdc;
                rise_p <= ~mdc;
                fall_p <= mdc;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mdio_frame.sv
// Frame sequencer and command register.
// Walks 64 bit times: 32 preamble ones, then the command MSB first.
// Advances on each falling-edge strobe, so data changes while mdc is low.
// On reads, releases the line from the turnaround onward and shifts
// sampled bits into the low half. Ignores writes while busy or disabled.
module mdio_frame
    import mdio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                cmd_we,
    input  logic [CMD_BITS-1:0] cmd_wdata,
    input  logic                rise_p,
    input  logic                fall_p,
    input  logic                mdio_i,
    output logic [CMD_BITS-1:0] cmd_q,
    output logic                busy,
    output logic                launch,
    output logic                mdio_o,
    output logic                mdio_oe
);
    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam int POS_W = $clog2(CMD_BITS);

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] rev;
    logic [POS_W-1:0] pos;
    logic             is_rd;

    assign launch = cmd_we & en & ~busy;
    assign rev    = IDX_W'(FRAME_BITS - 1) - idx;
    assign pos    = rev[POS_W-1:0];

    // Sequencer state, command capture and read-data shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
            busy  <= 1'b0;
            idx   <= '0;
            is_rd <= 1'b0;
        end else if (!en) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (launch) begin
            cmd_q <= cmd_wdata;
            busy  <= 1'b1;
            idx   <= '0;
            is_rd <= (cmd_wdata[OP_HI:OP_LO] == OP_READ);
        end else if (busy) begin
            if (fall_p) begin
                if (idx == IDX_W'(FRAME_BITS - 1)) begin
                    busy <= 1'b0;
                    idx  <= '0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
            if (rise_p && is_rd && idx >= IDX_W'(DATA_FIRST))
                cmd_q[DATA_W-1:0] <= {cmd_q[DATA_W-2:0], mdio_i};
        end
    end

    // Line drive: preamble ones, then command bits; released on read tail.
    always_comb begin
        if (!busy || idx < IDX_W'(PRE_BITS)) mdio_o = 1'b1;
        else                                 mdio_o = cmd_q[pos];
        mdio_oe = busy & ~(is_rd & (idx >= IDX_W'(TA_FIRST)));
    end
endmodule

// File: rtl/mdio_mgmt.sv
// Top of the management frame engine.
// Joins the clock generator and the frame sequencer.
// The divider runs only while a frame is in flight and the port is enabled.
module mdio_mgmt #(
    parameter int BASE_DIV = 8,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mgmt_en,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             cmd_we,
    input  logic [31:0]      cmd_wdata,
    output logic [31:0]      cmd_rdata,
    output logic             idle,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    logic busy, launch, rise_p, fall_p;

    mdio_clkgen #(.BASE_DIV(BASE_DIV), .SEL_W(SEL_W)) u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy & mgmt_en),
        .launch (launch),
        .sel    (clk_sel),
        .mdc    (mdc),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    mdio_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (mgmt_en),
        .cmd_we    (cmd_we),
        .cmd_wdata (cmd_wdata),
        .rise_p    (rise_p),
        .fall_p    (fall_p),
        .mdio_i    (mdio_i),
        .cmd_q     (cmd_rdata),
        .busy      (busy),
        .launch    (launch),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    assign idle = ~busy;
endmodule

// File: rtl/mdio_mgmt_chk.sv
// Property checker for mdio_mgmt, attached by bind. Observes ports only.
module mdio_mgmt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mgmt_en,
    input logic        cmd_we,
    input logic [31:0] cmd_rdata,
    input logic        idle,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    // R4: clock quiet while idle
    p_mdc_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !mdc);

    // R8: disabling the port leaves the block idle next cycle
    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mgmt_en |=> idle);

    // R5: output enable changes only while the clock is low
    p_oe_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_oe) |-> !mdc);

    // R5: driven value changes only while the clock is low
    p_drive_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && !$stable(mdio_o)) |-> !mdc);

    // R7: upper command half untouched while a frame is in flight
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && $past(!idle)) |-> $stable(cmd_rdata[31:16]));

    // R6: an accepted write starts a driven frame next cycle
    p_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && cmd_we && mgmt_en) |=> (!idle && mdio_oe));
endmodule

bind mdio_mgmt mdio_mgmt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mgmt_en   (mgmt_en),
    .cmd_we    (cmd_we),
    .cmd_rdata (cmd_rdata),
    .idle      (idle),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/mdio_mgmt_test.sv
`timescale 1ns/1ps
module mdio_mgmt_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mgmt_en = 1'b1;
    logic [1:0]  clk_sel = 2'd0;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        idle, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    mdio_mgmt uut (
        .clk(clk), .rst_n(rst_n), .mgmt_en(mgmt_en), .clk_sel(clk_sel),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
        .idle(idle), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor and PHY model
    int          mon_n = 64;
    logic [63:0] cap_o, cap_oe;
    realtime     t_first, t_last;
    int          edge_bad;
    logic        last_o, last_oe;
    logic [15:0] phy_data;

    always @(posedge mdc) begin
        if (mon_n < 64) begin
            cap_o[63-mon_n]  = mdio_o;
            cap_oe[63-mon_n] = mdio_oe;
            if (mon_n == 0) t_first = $realtime;
            t_last = $realtime;
        end
        last_o  = mdio_o;
        last_oe = mdio_oe;
        mon_n++;
    end

    always @(negedge mdc) begin
        if (mon_n >= 48 && mon_n < 64) mdio_i = phy_data[63-mon_n];
        else                           mdio_i = 1'b1;
    end

    always @(negedge clk) begin
        if (mdc && (mdio_oe !== last_oe || (mdio_oe && mdio_o !== last_o)))
            edge_bad++;
    end

    // Watchdog
    initial begin
        #900000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Vector table: {sel, cmd, phy reply}
    localparam int NV = 4;
    localparam logic [49:0] VEC [NV] = '{
        {2'd0, 32'h50821234, 16'h0000},
        {2'd1, 32'h618A0000, 16'hBEEF},
        {2'd3, 32'h6FFEFFFF, 16'h0001},
        {2'd2, 32'h5002A5A5, 16'h0000}
    };

    task automatic txn(input logic [1:0] sel, input logic [31:0] cmd,
                       input logic [15:0] pd, input int mode,
                       output int cycles);
        @(negedge clk);
        clk_sel = sel; cmd_wdata = cmd; cmd_we = 1'b1;
        phy_data = pd; edge_bad = 0; mon_n = 0;
        @(negedge clk);
        cmd_we = 1'b0;
        cycles = 0;
        while (!idle && cycles < 20000) begin
            cycles++;
            if (mode == 1 && cycles == 200) begin cmd_we = 1'b1; cmd_wdata = ~cmd; end
            if (mode == 1 && cycles == 201) cmd_we = 1'b0;
            if (mode == 2 && cycles == 200) clk_sel = ~sel;
            @(negedge clk);
        end
    endtask

    function automatic bit is_read(input logic [31:0] c);
        return c[29:28] == 2'b10;
    endfunction

    initial begin
        int cyc;
        repeat (4) @(negedge clk);
        // R9: reset state
        chk(idle === 1'b1 && mdc === 1'b0 && mdio_oe === 1'b0 && cmd_rdata === 32'h0,
            "R9 reset state", {29'h0, idle, mdc, mdio_oe, cmd_rdata}, {29'h4, 32'h0});
        rst_n = 1'b1;
        @(negedge clk);
        chk(idle === 1'b1, "R6 idle after reset", {63'h0, idle}, 64'h1);

        for (int v = 0; v < NV; v++) begin
            logic [1:0]  s;
            logic [31:0] c;
            logic [15:0] p;
            logic [63:0] ef, eoe;
            int          dv;
            s = VEC[v][49:48]; c = VEC[v][47:16]; p = VEC[v][15:0];
            dv = 8 << s;
            ef = {32'hFFFFFFFF, c};
            eoe = is_read(c) ? 64'hFFFF_FFFF_FFFC_0000 : {64{1'b1}};
            txn(s, c, p, 0, cyc);
            chk(cap_oe == eoe, is_read(c) ? "R2 read release pattern" : "R1 write drives all bits",
                cap_oe, eoe);
            chk((cap_o & eoe) == (ef & eoe), is_read(c) ? "R2 read header bits" : "R1 frame bits",
                cap_o, ef);
            chk(int'((t_last - t_first) / (63.0 * 5.0)) == dv, "R4 clock period",
                64'(int'((t_last - t_first) / 5.0)), 64'(63 * dv));
            chk(cyc == 64 * dv + 1, "R6 busy duration", 64'(cyc), 64'(64 * dv + 1));
            chk(cmd_rdata == (is_read(c) ? {c[31:16], p} : c),
                is_read(c) ? "R3 read data capture" : "R1 register after write",
                {32'h0, cmd_rdata}, {32'h0, is_read(c) ? {c[31:16], p} : c});
            chk(edge_bad == 0, "R5 changes only while mdc low", 64'(edge_bad), 64'h0);
            chk(mdc === 1'b0, "R4 clock low when idle", {63'h0, mdc}, 64'h0);
        end

        // R7: write during a frame is ignored
        txn(2'd0, 32'h5002A5A5, 16'h0, 1, cyc);
        chk(cap_o == {32'hFFFFFFFF, 32'h5002A5A5}, "R7 frame unchanged by busy write",
            cap_o, {32'hFFFFFFFF, 32'h5002A5A5});
        chk(cmd_rdata == 32'h5002A5A5, "R7 register unchanged by busy write",
            {32'h0, cmd_rdata}, {32'h0, 32'h5002A5A5});
        chk(cyc == 513, "R7 frame length unchanged", 64'(cyc), 64'd513);

        // R4: divide select change mid-frame has no effect
        txn(2'd0, 32'h50821234, 16'h0, 2, cyc);
        chk(int'((t_last - t_first) / (63.0 * 5.0)) == 8, "R4 select captured at launch",
            64'(int'((t_last - t_first) / 5.0)), 64'(63 * 8));
        chk(cyc == 513, "R4 duration with select change", 64'(cyc), 64'd513);

        // R8: writes ignored while disabled
        @(negedge clk);
        mgmt_en = 1'b0; clk_sel = 2'd0; cmd_wdata = 32'h618A0000; cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
        chk(idle === 1'b1 && mdc === 1'b0, "R8 disabled write no launch",
            {62'h0, idle, mdc}, 64'h2);
        @(negedge clk);
        chk(cmd_rdata == 32'h50821234, "R8 disabled write ignored",
            {32'h0, cmd_rdata}, {32'h0, 32'h50821234});

        // R8: abort mid-frame, then a normal read
        mgmt_en = 1'b1;
        cmd_we = 1'b1; cmd_wdata = 32'h5002A5A5;
        @(negedge clk);
        cmd_we = 1'b0;
        repeat (101) @(negedge clk);
        chk(idle === 1'b0, "R8 frame in flight before abort", {63'h0, idle}, 64'h0);
        mgmt_en = 1'b0;
        @(negedge clk);
        chk(idle === 1'b1 && mdc === 1'b0 && mdio_oe === 1'b0, "R8 abort on disable",
            {61'h0, idle, mdc, mdio_oe}, 64'h4);
        mgmt_en = 1'b1;
        txn(2'd0, 32'h618A0000, 16'h5A3C, 0, cyc);
        chk(cmd_rdata == 32'h618A5A3C, "R3 read after abort",
            {32'h0, cmd_rdata}, {32'h0, 32'h618A5A3C});
        chk(cyc == 513, "R6 duration after abort", 64'(cyc), 64'd513);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule